// File: doc/BRIEF.md
# Pixel Stream Backpressure FIFO

This block is a synchronous buffer placed in a streaming video path. Each incoming beat carries a pixel word and four framing flags: line first, line last, frame first and frame last. The beat is written only when the input valid is high. The pixel word and its flags are kept in one shared storage entry, so they leave the buffer exactly as they arrived.

The upstream ready output comes straight from the registered occupancy. It drops while there is still one free entry left. A producer that stops one cycle after ready falls can therefore still place its last beat without loss.

The read side offers the oldest beat with a valid/ready handshake. If a beat is presented while the buffer is truly full, the beat is refused and a sticky overflow flag is raised.

Top module: `pix_bp_fifo`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and overflow_o is 0.
- R2: Beats leave in the order they were written. On the output, pixel word and all four flags match the same input beat. A beat is compared as the 12-bit value {hstart, hend, vstart, vend, data[7:0]} with default parameters.
- R3: in_ready_o is low in exactly the cycles where the number of free entries is 1 or 0. With DEPTH=8 it stays high after 6 unread writes and is low after 7. It depends on the registered occupancy only, with no added delay.
- R4: One beat presented in the cycle after in_ready_o falls is stored and later read out intact, and overflow_o stays 0.
- R5: A beat presented while all DEPTH entries are occupied is not stored and sets overflow_o in the next cycle. The stored contents are unchanged.
- R6: overflow_o stays high until the next reset.
- R7: out_valid_o is high exactly when at least one beat is stored. While out_valid_o is high and out_ready_i is low, the output word and flags hold steady.
- R8: A cycle with both an accepted write and a read leaves the occupancy unchanged, as seen on in_ready_o and on later reads.
- R9: Input data and flags presented with in_valid_i low are ignored. No beat appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat qualifier |
| in_data_i | input | DATA_W | Input pixel word |
| in_hstart_i | input | 1 | First active pixel of a line |
| in_hend_i | input | 1 | Last active pixel of a line |
| in_vstart_i | input | 1 | First active pixel of a frame |
| in_vend_i | input | 1 | Last active pixel of a frame |
| in_ready_o | output | 1 | Backpressure toward the producer |
| out_valid_o | output | 1 | Output beat available |
| out_data_o | output | DATA_W | Output pixel word |
| out_hstart_o | output | 1 | Line first flag of output beat |
| out_hend_o | output | 1 | Line last flag of output beat |
| out_vstart_o | output | 1 | Frame first flag of output beat |
| out_vend_o | output | 1 | Frame last flag of output beat |
| out_ready_i | input | 1 | Consumer accepts the output beat |
| overflow_o | output | 1 | Sticky: a beat was refused at full |

## Verification
The buffer is tried with several input patterns:

- **Idle input.** Data and flags toggle with valid low. This separates a correct write qualifier from one that ignores valid.
- **Fill with no reads.** The buffer is filled without reading, and a late beat is added after ready falls. This locates the exact ready threshold and shows whether the margin entry absorbs the late beat.
- **Stalled consumer.** Reads are held off for several cycles, which exposes any output that changes while not accepted.
- **Streaming near the threshold.** Concurrent reads and writes run just below the threshold, and a final write then tips ready low. This shows whether the occupancy drifts on combined cycles.
- **Push at true full.** A beat is pushed against a completely full buffer. Draining afterwards shows whether the refused beat corrupted or joined the contents, and whether the overflow flag holds.

// File: rtl/pix_fifo_pkg.sv
`timescale 1ns/1ps
package pix_fifo_pkg;
  localparam int unsigned PIX_FLAG_W = 4;

  typedef struct packed {
    logic line_first;
    logic line_last;
    logic frame_first;
    logic frame_last;
  } pix_flags_t;
endpackage

// File: rtl/pix_fifo_store.sv
`timescale 1ns/1ps
module pix_fifo_store #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_addr_i == AW'(g)) entry_q[g] <= wr_word_i;
    end
  end

  assign rd_word_o = entry_q[rd_addr_i];
endmodule

// File: rtl/pix_fifo_ctrl.sv
`timescale 1ns/1ps
module pix_fifo_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_req_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          not_empty_o,
  output logic          in_ready_o,
  output logic          overflow_o
);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] STOP_LVL = CW'(DEPTH - 1);

  logic [CW-1:0] count_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          ovf_q;
  logic          full_w, rd_en_w;

  assign full_w      = (count_q == FULL_LVL);
  assign not_empty_o = (count_q != '0);
  assign wr_en_o     = push_i & ~full_w;
  assign rd_en_w     = not_empty_o & pop_req_i;
  // keep one entry spare for the beat that arrives after ready drops
  assign in_ready_o  = (count_q < STOP_LVL);
  assign wr_addr_o   = wr_ptr_q;
  assign rd_addr_o   = rd_ptr_q;
  assign overflow_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_en_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_w) rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({wr_en_o, rd_en_w})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_i && full_w) ovf_q <= 1'b1;
    end
  end

  a_r8_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && rd_en_w) |=> $stable(count_q));
  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r3_ready_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> (count_q == STOP_LVL));
  a_r5_full_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_w && push_i && !pop_req_i) |=> (count_q == FULL_LVL) && overflow_o);

  always_comb begin
    a_r3_count_bound: assert (!rst_ni || count_q <= FULL_LVL);
  end
endmodule

// File: rtl/pix_bp_fifo.sv
`timescale 1ns/1ps
module pix_bp_fifo
  import pix_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_hstart_i,
  input  logic              in_hend_i,
  input  logic              in_vstart_i,
  input  logic              in_vend_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_hstart_o,
  output logic              out_hend_o,
  output logic              out_vstart_o,
  output logic              out_vend_o,
  input  logic              out_ready_i,
  output logic              overflow_o
);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned WORD_W = DATA_W + PIX_FLAG_W;

  pix_flags_t        in_flags, out_flags;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;

  assign in_flags = '{line_first: in_hstart_i, line_last: in_hend_i,
                      frame_first: in_vstart_i, frame_last: in_vend_i};
  assign wr_word  = {in_flags, in_data_i};

  pix_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (in_valid_i),
    .pop_req_i   (out_ready_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_addr_o   (rd_addr),
    .not_empty_o (out_valid_o),
    .in_ready_o  (in_ready_o),
    .overflow_o  (overflow_o)
  );

  pix_fifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_word_i (wr_word),
    .rd_addr_i (rd_addr),
    .rd_word_o (rd_word)
  );

  assign {out_flags, out_data_o} = rd_word;
  assign out_hstart_o = out_flags.line_first;
  assign out_hend_o   = out_flags.line_last;
  assign out_vstart_o = out_flags.frame_first;
  assign out_vend_o   = out_flags.frame_last;

  a_r7_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(rd_word));
  a_r9_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !out_valid_o) |=> !out_valid_o);
endmodule

// File: tb/tb_pix_bp_fifo.sv
`timescale 1ns/1ps
module tb_pix_bp_fifo;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_hs = 1'b0, in_he = 1'b0, in_vs = 1'b0, in_ve = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_hs, out_he, out_vs, out_ve, overflow;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [11:0] q[$];
  bit ovf_m = 1'b0;

  always #2 clk = ~clk;

  pix_bp_fifo #(.DATA_W(8), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .in_hstart_i(in_hs), .in_hend_i(in_he), .in_vstart_i(in_vs), .in_vend_i(in_ve),
    .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .out_hstart_o(out_hs), .out_hend_o(out_he), .out_vstart_o(out_vs), .out_vend_o(out_ve),
    .out_ready_i(out_ready), .overflow_o(overflow)
  );

  function automatic logic [11:0] mk(input int i);
    mk = {4'(i * 5 + 3), 8'(i * 37 + 5)};
  endfunction

  function automatic logic [11:0] got();
    got = {out_hs, out_he, out_vs, out_ve, out_data};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "out_valid", 32'(out_valid), 32'(q.size() != 0));
    chk(req, "in_ready", 32'(in_ready), 32'(q.size() < DEPTH - 1));
    chk(req, "overflow", 32'(overflow), 32'(ovf_m));
    if (q.size() != 0) chk(req, "beat", 32'(got()), 32'(q[0]));
  endtask

  task automatic cyc(input bit v, input bit r, input logic [11:0] b);
    bit acc, pop;
    in_valid = v; out_ready = r;
    {in_hs, in_he, in_vs, in_ve, in_data} = b;
    pop = r && q.size() > 0;
    acc = v && q.size() < DEPTH;
    if (v && q.size() == DEPTH) ovf_m = 1'b1;
    @(posedge clk); #1;
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(b);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; q.delete(); ovf_m = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic drain(input string req);
    while (q.size() != 0) begin
      check_state(req);
      cyc(1'b0, 1'b1, '0);
    end
    check_state(req);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "in_ready", 32'(in_ready), 1);
    chk("R1", "overflow", 32'(overflow), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0, mk(100 + i));
      chk("R9", "out_valid idle", 32'(out_valid), 0);
    end
    check_state("R9");
  endtask

  task automatic t_fill_late();
    for (int i = 0; i < DEPTH - 1; i++) begin
      chk("R3", "ready before write", 32'(in_ready), 1);
      cyc(1'b1, 1'b0, mk(i));
      check_state("R3");
    end
    chk("R3", "ready low at margin", 32'(in_ready), 0);
    cyc(1'b1, 1'b0, mk(50));                      // late beat
    chk("R4", "late beat no overflow", 32'(overflow), 0);
    chk("R4", "stored count", 32'(q.size()), 32'(DEPTH));
    drain("R2");
    chk("R4", "late beat fits, overflow", 32'(overflow), 0);
  endtask

  task automatic t_stall();
    logic [11:0] first;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, mk(200 + i));
    first = got();
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, '0);
      chk("R7", "held beat", 32'(got()), 32'(first));
      chk("R7", "held valid", 32'(out_valid), 1);
    end
    drain("R7");
    chk("R7", "empty valid", 32'(out_valid), 0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < DEPTH - 2; i++) cyc(1'b1, 1'b0, mk(300 + i));
    for (int i = 0; i < 5; i++) begin
      check_state("R8");
      cyc(1'b1, 1'b1, mk(400 + i));
    end
    chk("R8", "ready after combined cycles", 32'(in_ready), 1);
    cyc(1'b1, 1'b0, mk(500));
    chk("R8", "ready after one more write", 32'(in_ready), 0);
    drain("R8");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, mk(600 + i));
    chk("R5", "overflow before extra", 32'(overflow), 0);
    cyc(1'b1, 1'b0, mk(777));
    chk("R5", "overflow set", 32'(overflow), 1);
    drain("R5");
    chk("R6", "overflow sticky after drain", 32'(overflow), 1);
    cyc(1'b0, 1'b0, '0);
    chk("R6", "overflow sticky idle", 32'(overflow), 1);
    do_reset();
    chk("R1", "overflow cleared by reset", 32'(overflow), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_fill_late();
    t_stall();
    t_simul();
    t_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule